// File: doc/BRIEF.md
# ADC Result FIFO with Error Monitor

This block is the capture back end of an acquisition board. An external trigger arms it. After that, each convert request starts one conversion on a converter, which is modelled here as a busy window of fixed length. When the window closes, the result goes into a 512-entry first-in first-out store. Host software polls a 16-bit status word and pops results through a data register. It empties the store with a clear register.

Two faults are watched and latched as sticky status flags:
- **Overflow:** a result arrives while the store is already full, so that result is lost.
- **Overrun:** a convert request arrives while a conversion is still busy.

Either fault halts acquisition. The host then has to clear the block and re-trigger it.

The register bus is a simple strobe interface with a combinational read path:
- Address 0 is the status word.
- Address 1 is the data register.
- Address 2 is the clear register.
- Address 3 reads as zero.

A read strobe on address 1 pops one entry at the clock edge.

Top module: `adc_capture_top`

## Requirements
- R1: The store keeps up to FIFO_DEPTH (default 512) results and returns them in the order they completed.
- R2: A result that completes when the store holds FIFO_DEPTH entries, with no pop in the same cycle, is dropped. Status bit 12 (overflow) is then set and stays set, and acquisition halts.
- R3: A convert request accepted while the block is running but the converter is busy sets status bit 11 (overrun), which stays set, and acquisition halts.
- R4: Once halted, convert requests start no conversion, so busy_o stays low.
- R5: Status bit 13 reads 1 exactly when at least one result is stored. All status bits other than 13, 12 and 11 read 0.
- R6: A read strobe on address 1 returns the oldest entry and removes it. On an empty store it returns 0 and changes nothing.
- R7: An accepted request raises busy_o from the next cycle for CONV_CYCLES cycles. The result is written in the first cycle busy_o is low again, so bit 13 rises one cycle later.
- R8: A write of value 0 to address 2 empties the store, clears bits 12 and 11, and returns the block to the untriggered state. A write of any other value to address 2 has no effect.
- R9: Before a trigger pulse, convert requests are ignored. Trigger pulses while running or halted are ignored.
- R10: A pop and a completing result in the same cycle are both honoured, even on a full store, and no overflow is flagged.
- R11: A clear write takes priority over a same-cycle pop, result write, trigger and convert request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | External start trigger pulse |
| conv_req_i | input | 1 | Convert request pulse |
| sample_i | input | DATA_W | Converter value captured when a request is accepted |
| busy_o | output | 1 | Converter busy window |
| bus_addr_i | input | 2 | Register address (0 status, 1 data, 2 clear) |
| bus_rd_i | input | 1 | Read strobe; pops on address 1 |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data |

## Verification
The bench fills the store to exactly 512 entries and then lands one more result. A design with an off-by-one full test would either flag overflow one entry early or overwrite the oldest sample.

It also places a pop in the exact cycle a result lands on a full store. A design that treated full as a hard block would lose that result and falsely halt.

Three further cases are covered:
- A second request one cycle after the first, which must flag overrun.
- A non-zero write to the clear address, which must leave the sticky flags alone.
- A clear in the cycle a result completes, which must leave the store empty. A wrong priority order would leave one stale sample behind.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_RUN  = 2'd1,
    ACQ_HALT = 2'd2
  } acq_state_e;

  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_DATA   = 2'd1;
  localparam logic [1:0] REG_CLEAR  = 2'd2;

  localparam int BIT_AVAIL = 13;
  localparam int BIT_OVF   = 12;
  localparam int BIT_OVR   = 11;

  function automatic logic [15:0] pack_status(input logic avail, input logic ovf, input logic ovr);
    logic [15:0] s;
    s            = '0;
    s[BIT_AVAIL] = avail;
    s[BIT_OVF]   = ovf;
    s[BIT_OVR]   = ovr;
    return s;
  endfunction

  function automatic int count_step(input int cnt, input logic push, input logic pop);
    return cnt + int'(push) - int'(pop);
  endfunction

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CONV_CYCLES = 20,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int TW = $clog2(CONV_CYCLES + 1);

  logic [TW-1:0]     cnt_q;
  logic              done_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= (cnt_q == TW'(1));
      if (start_i) begin
        cnt_q <= TW'(CONV_CYCLES);
        res_q <= sample_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign done_o   = done_q;
  assign result_o = res_q;

  // R7: the result strobe appears in the first cycle after the busy window
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R4: the controller never starts a conversion on top of a busy one
  p_start_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_next(rd_ptr_q);
      count_q <= CW'(adc_cap_pkg::count_step(int'(count_q), push_i, pop_i));
    end
  end

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;
  assign head_o  = mem[rd_ptr_q];

  // R2: a write reaches a full store only together with a pop
  p_push_has_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o) |-> pop_i);
  // R6: pops never underflow
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R1: occupancy never exceeds the depth
  p_count_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH));
  // R10: simultaneous push and pop keep the occupancy
  p_push_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !flush_i) |=> $stable(count_o));
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic trig_i,
  input  logic req_i,
  input  logic busy_i,
  input  logic done_i,
  input  logic full_i,
  input  logic pop_i,
  output logic start_o,
  output logic push_o,
  output logic ovf_o,
  output logic ovr_o,
  output adc_cap_pkg::acq_state_e state_o
);
  import adc_cap_pkg::*;

  acq_state_e state_q, state_d;
  logic       ovf_q, ovr_q;
  logic       running, ovf_evt, ovr_evt;

  assign running = (state_q == ACQ_RUN);
  assign ovf_evt = done_i && full_i && !pop_i && !clear_i;
  assign ovr_evt = running && req_i && busy_i && !clear_i;
  assign push_o  = done_i && (!full_i || pop_i) && !clear_i;
  assign start_o = running && req_i && !busy_i && !ovf_evt && !clear_i;

  always_comb begin
    state_d = state_q;
    if (clear_i)                           state_d = ACQ_IDLE;
    else if (ovf_evt || ovr_evt)           state_d = ACQ_HALT;
    else if (state_q == ACQ_IDLE && trig_i) state_d = ACQ_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACQ_IDLE;
      ovf_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clear_i) begin
        ovf_q <= 1'b0;
        ovr_q <= 1'b0;
      end else begin
        if (ovf_evt) ovf_q <= 1'b1;
        if (ovr_evt) ovr_q <= 1'b1;
      end
    end
  end

  assign ovf_o   = ovf_q;
  assign ovr_o   = ovr_q;
  assign state_o = state_q;

  // R2: overflow flag is sticky until a clear
  p_overflow_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clear_i) |=> ovf_o);
  // R3: a request during a busy window while running raises the overrun flag
  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ACQ_RUN && req_i && busy_i && !clear_i) |=> (ovr_o && state_o == ACQ_HALT));
  // R4 and R9: conversions start only in the running state
  p_no_start_unless_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != ACQ_RUN) |-> !start_o);
  // R8: a clear drops both flags and returns to idle
  p_clear_resets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!ovf_o && !ovr_o && state_o == ACQ_IDLE));
endmodule

// File: rtl/adc_capture_top.sv
module adc_capture_top #(
  parameter int CONV_CYCLES = 20,
  parameter int FIFO_DEPTH  = 512,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              conv_req_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [15:0]       bus_wdata_i,
  output logic [15:0]       bus_rdata_o
);
  import adc_cap_pkg::*;

  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic              clear_w, pop_w, push_w, start_w;
  logic              busy_w, done_w, empty_w, full_w, ovf_w, ovr_w;
  logic [DATA_W-1:0] result_w, head_w;
  logic [CW-1:0]     count_w;
  logic [15:0]       status_w;
  acq_state_e        state_w;

  assign clear_w = bus_wr_i && (bus_addr_i == REG_CLEAR) && (bus_wdata_i == 16'd0);
  assign pop_w   = bus_rd_i && (bus_addr_i == REG_DATA) && !empty_w && !clear_w;

  adc_conv_timer #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .sample_i(sample_i),
    .busy_o(busy_w), .done_o(done_w), .result_o(result_w)
  );

  adc_result_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(clear_w), .push_i(push_w), .pop_i(pop_w),
    .wdata_i(result_w), .head_o(head_w), .empty_o(empty_w), .full_o(full_w),
    .count_o(count_w)
  );

  adc_acq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .trig_i(trig_i), .req_i(conv_req_i),
    .busy_i(busy_w), .done_i(done_w), .full_i(full_w), .pop_i(pop_w),
    .start_o(start_w), .push_o(push_w), .ovf_o(ovf_w), .ovr_o(ovr_w), .state_o(state_w)
  );

  assign status_w = pack_status(!empty_w, ovf_w, ovr_w);
  assign busy_o   = busy_w;

  always_comb begin
    bus_rdata_o = 16'd0;
    case (bus_addr_i)
      REG_STATUS: bus_rdata_o = status_w;
      REG_DATA:   bus_rdata_o = empty_w ? 16'd0 : 16'(head_w);
      default:    bus_rdata_o = 16'd0;
    endcase
  end

  // R5: popping the last entry with nothing arriving clears the availability bit
  p_avail_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_w && count_w == CW'(1) && !push_w) |=> !status_w[BIT_AVAIL]);
  // R11: a clear leaves the store empty on the next cycle
  p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |=> empty_w);
  // R6: an empty data read leaves the occupancy unchanged
  p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == REG_DATA && empty_w && !push_w && !clear_w) |=> empty_w);
endmodule

// File: tb/adc_capture_top_test.sv
module adc_capture_top_test;
  localparam int C     = 3;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig, req, rd, wr, busy;
  logic [15:0] samp, wdata, rdata;
  logic [1:0]  addr;

  always #5 clk = ~clk;

  adc_capture_top #(.CONV_CYCLES(C), .FIFO_DEPTH(DEPTH), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .conv_req_i(req), .sample_i(samp),
    .busy_o(busy), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int last_rd;

  // behavioural reference
  int mq[$];
  int m_cnt = 0, m_res = 0, m_st = 0;
  bit m_done = 0, m_ovf = 0, m_ovr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_status();
    return ((mq.size() > 0) ? (1 << 13) : 0) | (m_ovf ? (1 << 12) : 0) | (m_ovr ? (1 << 11) : 0);
  endfunction

  task automatic compare_all();
    chk("R7 busy window", int'(busy), (m_cnt != 0) ? 1 : 0);
    if (addr == 2'd0) begin
      chk("R5 avail bit", int'(rdata[13]), (mq.size() > 0) ? 1 : 0);
      chk("R2 overflow bit", int'(rdata[12]), int'(m_ovf));
      chk("R3 overrun bit", int'(rdata[11]), int'(m_ovr));
      chk("R5 status word", int'(rdata), m_status());
    end else if (addr == 2'd1) begin
      chk("R6 data read", int'(rdata), (mq.size() > 0) ? mq[0] : 0);
    end else begin
      chk("R6 unused read", int'(rdata), 0);
    end
  endtask

  task automatic model_step();
    bit clr, pop, dn, full, ovfe, ovre;
    int ncnt;
    clr    = wr && addr == 2'd2 && wdata == 16'd0;
    pop    = rd && addr == 2'd1 && mq.size() > 0 && !clr;
    dn     = m_done;
    m_done = (m_cnt == 1);
    ncnt   = (m_cnt > 0) ? m_cnt - 1 : 0;
    if (clr) begin
      mq.delete();
      m_ovf = 0; m_ovr = 0; m_st = 0;
    end else begin
      full = (mq.size() == DEPTH);
      ovfe = dn && full && !pop;
      ovre = (m_st == 1) && req && (m_cnt != 0);
      if (pop) void'(mq.pop_front());
      if (dn && !ovfe) mq.push_back(m_res);
      if (ovfe) m_ovf = 1;
      if (ovre) m_ovr = 1;
      if ((m_st == 1) && req && (m_cnt == 0) && !ovfe) begin
        ncnt  = C;
        m_res = int'(samp);
      end
      if (ovfe || ovre) m_st = 2;
      else if (m_st == 0 && trig) m_st = 1;
    end
    m_cnt = ncnt;
  endtask

  task automatic cyc(input bit t, input bit q, input int s, input bit r,
                     input bit w, input int a, input int d);
    @(negedge clk);
    trig = t; req = q; samp = 16'(s); rd = r; wr = w; addr = 2'(a); wdata = 16'(d);
    #1;
    compare_all();
    last_rd = int'(rdata);
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, base + i, 0, 0, 0, 0);
      idle(C);
    end
    idle(2);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; trig = 0; req = 0; rd = 0; wr = 0; samp = 0; addr = 0; wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    idle(1);
    chk("R5 reset status", last_rd, 0);

    // R9: request before trigger is ignored
    cyc(0, 1, 16'h0bad, 0, 0, 0, 0);
    idle(C + 2);
    chk("R9 no conversion before trigger", last_rd, 0);

    // trigger, three conversions, read back in order
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'h1111, 0, 0, 0, 0);
    idle(C);                          // busy cycles
    idle(1);                          // done cycle: busy low, bit 13 not yet
    chk("R7 avail one cycle after busy falls", last_rd, 0);
    idle(1);
    chk("R7 result visible", last_rd, 1 << 13);
    cyc(0, 1, 16'h2222, 0, 0, 0, 0); idle(C);
    cyc(0, 1, 16'h3333, 0, 0, 0, 0); idle(C + 2);
    cyc(0, 0, 0, 1, 0, 1, 0); chk("R1 first out", last_rd, 16'h1111);
    cyc(0, 0, 0, 1, 0, 1, 0); chk("R1 second out", last_rd, 16'h2222);
    cyc(0, 0, 0, 1, 0, 1, 0); chk("R1 third out", last_rd, 16'h3333);
    cyc(0, 0, 0, 1, 0, 1, 0); chk("R6 empty read gives 0", last_rd, 0);
    idle(1); chk("R6 empty read changes nothing", last_rd, 0);

    // R3: overrun on a request during busy
    cyc(0, 1, 16'h4444, 0, 0, 0, 0);
    cyc(0, 1, 16'h5555, 0, 0, 0, 0);
    idle(C + 2);
    chk("R3 overrun flagged", last_rd, (1 << 13) | (1 << 11));
    // R4: halted, request ignored, trigger ignored
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 16'h6666, 0, 0, 0, 0);
    idle(1);
    chk("R4 no busy after halt", int'(busy), 0);
    idle(C + 2);
    // R8: non-zero clear write ignored
    cyc(0, 0, 0, 0, 1, 2, 5);
    idle(1);
    chk("R8 nonzero clear ignored", last_rd, (1 << 13) | (1 << 11));
    cyc(0, 0, 0, 0, 1, 2, 0);
    idle(1);
    chk("R8 clear empties and drops flags", last_rd, 0);
    cyc(0, 1, 16'h7777, 0, 0, 0, 0);
    idle(1);
    chk("R8 idle after clear", int'(busy), 0);

    // R2: fill to depth, then one more
    cyc(1, 0, 0, 0, 0, 0, 0);
    fill(DEPTH, 16'h1000);
    chk("R2 full without overflow", last_rd, 1 << 13);
    cyc(0, 1, 16'hffff, 0, 0, 0, 0);
    idle(C + 2);
    chk("R2 overflow flagged", last_rd, (1 << 13) | (1 << 12));
    cyc(0, 1, 16'heeee, 0, 0, 0, 0);
    idle(1);
    chk("R4 halted after overflow", int'(busy), 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 1, 0, 1, 0);
      if (i == 0)         chk("R1 oldest kept", last_rd, 16'h1000);
      if (i == DEPTH - 1) chk("R2 last stored, extra dropped", last_rd, 16'h1000 + DEPTH - 1);
    end
    cyc(0, 0, 0, 1, 0, 1, 0);
    chk("R6 drained", last_rd, 0);

    // R10: pop in the exact cycle a result lands on a full store
    cyc(0, 0, 0, 0, 1, 2, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    fill(DEPTH, 16'h2000);
    cyc(0, 1, 16'h9999, 0, 0, 0, 0);
    idle(C);
    cyc(0, 0, 0, 1, 0, 1, 0);
    chk("R10 pop on full", last_rd, 16'h2000);
    idle(1);
    chk("R10 no overflow", last_rd, 1 << 13);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 0, 0, 1, 0, 1, 0);
      if (i == DEPTH - 1) chk("R10 landed result kept", last_rd, 16'h9999);
    end

    // R11: clear in the result-landing cycle
    cyc(0, 1, 16'habcd, 0, 0, 0, 0);
    idle(C);
    cyc(1, 1, 0, 0, 1, 2, 0);
    idle(2);
    chk("R11 clear wins", last_rd, 0);
    chk("R11 trigger ignored on clear", int'(busy), 0);

    summary();
    $finish;
  end
endmodule